// File: doc/BRIEF.md
# Parallel Drum Block Transfer Controller

This block runs a word-parallel rotating drum that holds 32 fields of 4096 words each. A processor drives it with three I/O commands, each carrying an 18-bit data word. The read setup picks a read field, a read enable and a starting track address. The write setup picks a write field, a write enable and a word count, and its alternate form returns the current drum position. The start command loads the memory address and arms the transfer.

Once armed, the block waits for the word slot whose rotational position equals the track address. In each slot it does two things in order. If writing is enabled, it copies a memory word onto the drum. If reading is enabled, it then copies a drum word into memory. The read and write fields are independent, so a single slot can both store and fetch. After each word the track address and the low twelve bits of the memory address step on.

The alternate read setup arms a break-on-address wait. That wait moves no data and raises an interrupt when the position is reached. A store-ready input tells the block whether the drum storage is present. Drum storage and memory sit behind plain synchronous RAM ports.

Top module: `drum_xfer_ctrl`

## Requirements
- R1: The drum position advances by exactly one every CYC_PER_WORD clock cycles and wraps from 4095 to 0.
- R2: A read setup (select 1) clears busy and the error flag and cancels any armed operation. It loads the read enable (data bit 17), the read field (bits 16:12) and the track address (bits 11:0).
- R3: A write setup with the alternate bit set (select 2, alt 1) returns, one cycle later, a response word with bit 17 equal to the error flag, bits 16:12 zero and bits 11:0 the current position.
- R4: A start (select 3) sets busy. The first word moves in the slot where the position becomes equal to the track address. If they are already equal, that slot is a full revolution away. Every drum access happens while the position equals the low 12 bits of the drum address.
- R5: Within one slot the memory word is written to the drum at {write field, track address} before the drum word at {read field, track address} is read into memory. So when the two fields are equal, memory receives back its own word.
- R6: When the write enable is 0 no drum write occurs, and when the read enable is 0 no memory write occurs.
- R7: After each word the track address increments modulo 4096. Only memory address bits 11:0 increment, wrapping within the bank, and the upper bits stay fixed.
- R8: A word count of 0 (write setup bits 11:0) transfers 4096 words. Any other count N transfers N words.
- R9: When the last word of a transfer completes, busy clears and no interrupt is raised.
- R10: A read setup with the alternate bit set arms a break-on-address wait. When the position reaches the track address, a one-cycle interrupt pulse is raised and no RAM is written.
- R11: If store_ready is low when the position matches, the error flag sets, busy clears and nothing is transferred.
- R12: After reset busy, irq and the error flag are 0 and no RAM write is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe, one cycle |
| cmd_sel | input | 2 | 1 read setup, 2 write setup, 3 start |
| cmd_alt | input | 1 | Alternate form of the command |
| cmd_data | input | 18 | Command data word |
| rsp_valid | output | 1 | Position response valid |
| rsp_data | output | 18 | Position response word |
| busy | output | 1 | Transfer armed or running |
| irq | output | 1 | Break-on-address interrupt pulse |
| rot_pos | output | 12 | Current rotational position |
| store_ready | input | 1 | Drum storage present |
| drum_addr | output | 17 | Drum RAM address {field, track address} |
| drum_we | output | 1 | Drum RAM write enable |
| drum_wdata | output | 18 | Drum RAM write data |
| drum_rdata | input | 18 | Drum RAM read data, one cycle after address |
| mem_addr | output | 16 | Memory RAM address |
| mem_we | output | 1 | Memory RAM write enable |
| mem_wdata | output | 18 | Memory RAM write data |
| mem_rdata | input | 18 | Memory RAM read data, one cycle after address |

## Verification
On every cycle, the assertions check several properties: the position steps by at most one, each write enable is gated by its direction enable, a break wait never writes RAM and is the only source of an interrupt, busy implies a live count, and each finished word advances the track address while the memory bank stays fixed. Only the directed scenarios can show the data itself. Those cover the ordering of the drum write before the drum read, field independence, the full-track count of zero, the full-revolution wait on an equal address, the error path when storage is missing, and the position readback.

// File: rtl/drum_pkg.sv
package drum_pkg;
  typedef enum logic [1:0] {
    SEL_NONE   = 2'd0,
    SEL_RSETUP = 2'd1,
    SEL_WSETUP = 2'd2,
    SEL_START  = 2'd3
  } cmd_sel_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ARMED,
    ST_MOVE
  } ctl_st_e;

  typedef enum logic [2:0] {
    MV_IDLE,
    MV_MFETCH,
    MV_DWRITE,
    MV_DADDR,
    MV_DFETCH,
    MV_MWRITE,
    MV_DONE
  } mover_step_e;
endpackage

// File: rtl/drum_rotor.sv
module drum_rotor #(
  parameter int CYC_PER_WORD = 8,
  parameter int TA_W         = 12
) (
  input  logic            clk,
  input  logic            rst,
  output logic            tick,
  output logic [TA_W-1:0] pos
);
  localparam int PH_W = (CYC_PER_WORD > 1) ? $clog2(CYC_PER_WORD) : 1;
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(CYC_PER_WORD - 1);

  logic [PH_W-1:0] ph;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph   <= '0;
      pos  <= '0;
      tick <= 1'b0;
    end else begin
      tick <= 1'b0;
      if (ph == PH_LAST) begin
        ph   <= '0;
        pos  <= pos + 1'b1;
        tick <= 1'b1;
      end else begin
        ph <= ph + 1'b1;
      end
    end
  end

  // R1: position holds or steps by one
  p_pos_step_r1: assert property (@(posedge clk) disable iff (rst)
    (pos == $past(pos)) || (pos == $past(pos) + 1'b1));
endmodule

// File: rtl/drum_word_mover.sv
module drum_word_mover
  import drum_pkg::*;
#(
  parameter int WORD_W = 18,
  parameter int DA_W   = 17,
  parameter int MEM_AW = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [DA_W-1:0]   wr_addr,
  input  logic [DA_W-1:0]   rd_addr,
  input  logic [MEM_AW-1:0] mem_ptr,
  output logic              done,
  output logic [DA_W-1:0]   drum_addr,
  output logic              drum_we,
  output logic [WORD_W-1:0] drum_wdata,
  input  logic [WORD_W-1:0] drum_rdata,
  output logic [MEM_AW-1:0] mem_addr,
  output logic              mem_we,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic [WORD_W-1:0] mem_rdata
);
  mover_step_e step;

  assign done = (step == MV_DONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      step       <= MV_IDLE;
      drum_addr  <= '0;
      drum_we    <= 1'b0;
      drum_wdata <= '0;
      mem_addr   <= '0;
      mem_we     <= 1'b0;
      mem_wdata  <= '0;
    end else begin
      drum_we <= 1'b0;
      mem_we  <= 1'b0;
      if (go) begin
        mem_addr <= mem_ptr;
        step     <= MV_MFETCH;
      end else begin
        unique case (step)
          MV_MFETCH: step <= MV_DWRITE;
          MV_DWRITE: begin
            drum_we    <= wr_en;
            drum_addr  <= wr_addr;
            drum_wdata <= mem_rdata;
            step       <= MV_DADDR;
          end
          MV_DADDR: begin
            drum_addr <= rd_addr;
            step      <= MV_DFETCH;
          end
          MV_DFETCH: step <= MV_MWRITE;
          MV_MWRITE: begin
            mem_we    <= rd_en;
            mem_wdata <= drum_rdata;
            step      <= MV_DONE;
          end
          MV_DONE: step <= MV_IDLE;
          default: step <= MV_IDLE;
        endcase
      end
    end
  end

  // R6: each RAM write is gated by its direction enable
  p_drum_we_gate_r6: assert property (@(posedge clk) disable iff (rst)
    drum_we |-> wr_en);
  p_mem_we_gate_r6: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> rd_en);
endmodule

// File: rtl/drum_xfer_ctrl.sv
module drum_xfer_ctrl
  import drum_pkg::*;
#(
  parameter int WORD_W       = 18,
  parameter int TA_W         = 12,
  parameter int MEM_AW       = 16,
  parameter int CYC_PER_WORD = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  cmd_valid,
  input  logic [1:0]            cmd_sel,
  input  logic                  cmd_alt,
  input  logic [WORD_W-1:0]     cmd_data,
  output logic                  rsp_valid,
  output logic [WORD_W-1:0]     rsp_data,
  output logic                  busy,
  output logic                  irq,
  output logic [TA_W-1:0]       rot_pos,
  input  logic                  store_ready,
  output logic [WORD_W-2:0]     drum_addr,
  output logic                  drum_we,
  output logic [WORD_W-1:0]     drum_wdata,
  input  logic [WORD_W-1:0]     drum_rdata,
  output logic [MEM_AW-1:0]     mem_addr,
  output logic                  mem_we,
  output logic [WORD_W-1:0]     mem_wdata,
  input  logic [WORD_W-1:0]     mem_rdata
);
  localparam int EN_POS = WORD_W - 1;
  localparam int FLD_W  = WORD_W - 1 - TA_W;
  localparam int DA_W   = FLD_W + TA_W;
  localparam int CNT_W  = TA_W + 1;
  localparam logic [CNT_W-1:0] FULL_TRACK = CNT_W'(1 << TA_W);

  logic             tick;
  logic             rd_en, wr_en, brk, err;
  logic [FLD_W-1:0] rd_fld, wr_fld;
  logic [TA_W-1:0]  ta, wc;
  logic [MEM_AW-1:0] ma;
  logic [CNT_W-1:0] cnt;
  ctl_st_e          st;
  logic             word_done, ctl_cmd, hit, go;

  drum_rotor #(.CYC_PER_WORD(CYC_PER_WORD), .TA_W(TA_W)) u_rotor (
    .clk(clk), .rst(rst), .tick(tick), .pos(rot_pos)
  );

  assign ctl_cmd = cmd_valid && (cmd_sel == SEL_RSETUP || cmd_sel == SEL_START);
  assign hit     = (st == ST_ARMED) && tick && (rot_pos == ta) && !ctl_cmd;
  assign go      = hit && store_ready && !brk;

  drum_word_mover #(.WORD_W(WORD_W), .DA_W(DA_W), .MEM_AW(MEM_AW)) u_mover (
    .clk(clk), .rst(rst), .go(go), .wr_en(wr_en), .rd_en(rd_en),
    .wr_addr({wr_fld, ta}), .rd_addr({rd_fld, ta}), .mem_ptr(ma),
    .done(word_done),
    .drum_addr(drum_addr), .drum_we(drum_we), .drum_wdata(drum_wdata),
    .drum_rdata(drum_rdata),
    .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= ST_IDLE; busy <= 1'b0; irq <= 1'b0; err <= 1'b0; brk <= 1'b0;
      rd_en <= 1'b0; wr_en <= 1'b0; rd_fld <= '0; wr_fld <= '0;
      ta <= '0; wc <= '0; ma <= '0; cnt <= '0;
      rsp_valid <= 1'b0; rsp_data <= '0;
    end else begin
      irq       <= 1'b0;
      rsp_valid <= 1'b0;
      if (cmd_valid && cmd_sel == SEL_WSETUP) begin
        if (cmd_alt) begin
          rsp_valid <= 1'b1;
          rsp_data  <= {err, {FLD_W{1'b0}}, rot_pos};
        end else begin
          wr_en  <= cmd_data[EN_POS];
          wr_fld <= cmd_data[EN_POS-1:TA_W];
          wc     <= cmd_data[TA_W-1:0];
        end
      end
      if (ctl_cmd) begin
        if (cmd_sel == SEL_RSETUP) begin
          err    <= 1'b0;
          busy   <= 1'b0;
          rd_en  <= cmd_data[EN_POS];
          rd_fld <= cmd_data[EN_POS-1:TA_W];
          ta     <= cmd_data[TA_W-1:0];
          brk    <= cmd_alt;
          st     <= cmd_alt ? ST_ARMED : ST_IDLE;
        end else begin
          ma   <= cmd_data[MEM_AW-1:0];
          cnt  <= (wc == '0) ? FULL_TRACK : CNT_W'(wc);
          busy <= 1'b1;
          st   <= ST_ARMED;
        end
      end else begin
        unique case (st)
          ST_ARMED: if (hit) begin
            if (!store_ready) begin
              err <= 1'b1; busy <= 1'b0; irq <= brk; st <= ST_IDLE;
            end else if (brk) begin
              irq <= 1'b1; busy <= 1'b0; st <= ST_IDLE;
            end else begin
              st <= ST_MOVE;
            end
          end
          ST_MOVE: if (word_done) begin
            ta  <= ta + 1'b1;
            ma  <= {ma[MEM_AW-1:TA_W], ma[TA_W-1:0] + 1'b1};
            cnt <= cnt - 1'b1;
            if (cnt == CNT_W'(1)) begin
              busy <= 1'b0; st <= ST_IDLE;
            end else begin
              st <= ST_ARMED;
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R10: interrupts come only from a break wait, which never writes RAM
  p_irq_break_r10: assert property (@(posedge clk) disable iff (rst)
    irq |-> brk);
  p_break_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    (brk && st != ST_MOVE) |-> (!drum_we && !mem_we));
  // R8: a busy transfer always has words left
  p_cnt_live_r8: assert property (@(posedge clk) disable iff (rst)
    busy |-> (cnt != '0));
  // R7: track address steps by one and the bank bits hold after each word
  p_ta_step_r7: assert property (@(posedge clk) disable iff (rst)
    (word_done && !cmd_valid) |=> (ta == $past(ta) + 1'b1));
  p_bank_fixed_r7: assert property (@(posedge clk) disable iff (rst)
    (word_done && !cmd_valid) |=> (ma[MEM_AW-1:TA_W] == $past(ma[MEM_AW-1:TA_W])));
  // R11: the error flag rises only as busy drops
  p_err_idle_r11: assert property (@(posedge clk) disable iff (rst)
    $rose(err) |-> !busy);
endmodule

// File: tb/drum_xfer_ctrl_tb.sv
module drum_xfer_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int CPW        = 8;

  logic        clk = 1'b0, rst = 1'b1;
  logic        cmd_valid = 1'b0, cmd_alt = 1'b0;
  logic [1:0]  cmd_sel = 2'd0;
  logic [17:0] cmd_data = '0;
  logic        rsp_valid, busy, irq, store_ready = 1'b1;
  logic [17:0] rsp_data, drum_wdata, mem_wdata;
  logic [17:0] drum_rdata = '0, mem_rdata = '0;
  logic [11:0] rot_pos;
  logic [16:0] drum_addr;
  logic [15:0] mem_addr;
  logic        drum_we, mem_we;

  int tests = 0, fails = 0;
  int n_dw = 0, n_mw = 0, n_irq = 0, addr_bad = 0;
  longint cyc = 0;
  logic [11:0] irq_pos = '0;

  logic [17:0] dr [int];
  logic [17:0] mm [int];

  drum_xfer_ctrl #(.CYC_PER_WORD(CPW)) u_dut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_sel(cmd_sel),
    .cmd_alt(cmd_alt), .cmd_data(cmd_data), .rsp_valid(rsp_valid),
    .rsp_data(rsp_data), .busy(busy), .irq(irq), .rot_pos(rot_pos),
    .store_ready(store_ready), .drum_addr(drum_addr), .drum_we(drum_we),
    .drum_wdata(drum_wdata), .drum_rdata(drum_rdata), .mem_addr(mem_addr),
    .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [17:0] dfun(input logic [16:0] a);
    return {1'b1, a};
  endfunction
  function automatic logic [17:0] mfun(input logic [15:0] a);
    return {2'b01, a ^ 16'h5A5A};
  endfunction
  function automatic logic [17:0] dget(input int a);
    return dr.exists(a) ? dr[a] : dfun(a[16:0]);
  endfunction
  function automatic logic [17:0] mget(input int a);
    return mm.exists(a) ? mm[a] : mfun(a[15:0]);
  endfunction

  always @(posedge clk) begin
    cyc <= cyc + 1;
    drum_rdata <= dget(int'(drum_addr));
    mem_rdata  <= mget(int'(mem_addr));
    if (drum_we) dr[int'(drum_addr)] = drum_wdata;
    if (mem_we)  mm[int'(mem_addr)]  = mem_wdata;
  end

  always @(negedge clk) begin
    if (drum_we) begin
      n_dw++;
      if (drum_addr[11:0] != rot_pos) addr_bad++;
    end
    if (mem_we) n_mw++;
    if (irq) begin
      n_irq++;
      irq_pos = rot_pos;
    end
  end

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic cmd(input logic [1:0] sel, input logic alt, input logic [17:0] d);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_sel = sel; cmd_alt = alt; cmd_data = d;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_sel = 2'd0; cmd_alt = 1'b0; cmd_data = '0;
  endtask

  task automatic readback(output logic [17:0] d);
    cmd(2'd2, 1'b1, '0);
    d = rsp_data;
  endtask

  task automatic wsetup(input logic en, input logic [4:0] f, input logic [11:0] n);
    cmd(2'd2, 1'b0, {en, f, n});
  endtask
  task automatic rsetup(input logic en, input logic [4:0] f, input logic [11:0] t, input logic alt);
    cmd(2'd1, alt, {en, f, t});
  endtask
  task automatic start(input logic [15:0] a);
    cmd(2'd3, 1'b0, {2'b00, a});
  endtask

  task automatic wait_idle(input string tag);
    int k = 0;
    while (busy && k < 40000) begin
      @(negedge clk);
      k++;
    end
    check(!busy, tag, busy, 0);
  endtask

  task automatic t_reset();
    logic [17:0] d;
    check(busy == 1'b0, "R12 busy", busy, 0);
    check(irq == 1'b0 && n_irq == 0, "R12 irq", n_irq, 0);
    check(n_dw == 0 && n_mw == 0, "R12 writes", n_dw + n_mw, 0);
    readback(d);
    check(d[17] == 1'b0, "R12 err", d[17], 0);
  endtask

  task automatic t_position();
    logic [17:0] a, b;
    logic [11:0] diff;
    readback(a);
    repeat (20 * CPW) @(negedge clk);
    readback(b);
    diff = b[11:0] - a[11:0];
    check(diff == 12'd20 || diff == 12'd21, "R1 step rate", diff, 20);
    check(b[16:12] == 5'd0 && rsp_valid, "R3 readback", b[16:12], 0);
  endtask

  task automatic t_write_only();
    int b_dw = n_dw, b_mw = n_mw;
    logic [11:0] t;
    wsetup(1'b1, 5'd3, 12'd5);
    t = rot_pos + 12'd4;
    rsetup(1'b0, 5'd0, t, 1'b0);
    start(16'h1200);
    check(busy == 1'b1, "R4 busy set", busy, 1);
    wait_idle("R9 write done");
    check(n_dw - b_dw == 5, "R8 count", n_dw - b_dw, 5);
    check(n_mw == b_mw, "R6 no mem write", n_mw - b_mw, 0);
    for (int i = 0; i < 5; i++) begin
      logic [16:0] da = {5'd3, t + 12'(i)};
      check(dget(int'(da)) == mfun(16'h1200 + 16'(i)), "R5 drum data", dget(int'(da)), mfun(16'h1200 + 16'(i)));
    end
  endtask

  task automatic t_read_only();
    int b_dw = n_dw, b_mw = n_mw;
    logic [11:0] t;
    wsetup(1'b0, 5'd0, 12'd3);
    t = rot_pos + 12'd4;
    rsetup(1'b1, 5'd7, t, 1'b0);
    start(16'h4400);
    wait_idle("R9 read done");
    check(n_dw == b_dw, "R6 no drum write", n_dw - b_dw, 0);
    check(n_mw - b_mw == 3, "R8 count rd", n_mw - b_mw, 3);
    for (int i = 0; i < 3; i++) begin
      logic [16:0] da = {5'd7, t + 12'(i)};
      check(mget(int'(16'h4400 + 16'(i))) == dfun(da), "R5 mem data", mget(int'(16'h4400 + 16'(i))), dfun(da));
    end
  endtask

  task automatic t_same_field();
    logic [11:0] t;
    wsetup(1'b1, 5'd2, 12'd2);
    t = rot_pos + 12'd4;
    rsetup(1'b1, 5'd2, t, 1'b0);
    start(16'h0200);
    wait_idle("R9 same done");
    check(mget(int'(16'h0201)) == mfun(16'h0201), "R5 write before read", mget(int'(16'h0201)), mfun(16'h0201));
    check(dget(int'({5'd2, t})) == mfun(16'h0200), "R5 same field drum", dget(int'({5'd2, t})), mfun(16'h0200));
  endtask

  task automatic t_swap_fields();
    logic [11:0] t;
    wsetup(1'b1, 5'd1, 12'd1);
    t = rot_pos + 12'd4;
    rsetup(1'b1, 5'd9, t, 1'b0);
    start(16'h0700);
    wait_idle("R9 swap done");
    check(dget(int'({5'd1, t})) == mfun(16'h0700), "R5 wr field", dget(int'({5'd1, t})), mfun(16'h0700));
    check(mget(int'(16'h0700)) == dfun({5'd9, t}), "R5 rd field", mget(int'(16'h0700)), dfun({5'd9, t}));
  endtask

  task automatic t_cancel();
    int b_dw = n_dw;
    logic [11:0] t;
    wsetup(1'b1, 5'd6, 12'd2);
    t = rot_pos + 12'd6;
    rsetup(1'b0, 5'd0, t, 1'b0);
    start(16'h0000);
    rsetup(1'b0, 5'd0, t, 1'b0);
    check(busy == 1'b0, "R2 busy cleared", busy, 0);
    repeat (16 * CPW) @(negedge clk);
    check(n_dw == b_dw, "R2 nothing moved", n_dw - b_dw, 0);
  endtask

  task automatic t_full_track();
    int b_dw = n_dw;
    logic [11:0] t;
    int bad = 0;
    wsetup(1'b1, 5'd4, 12'd0);
    t = rot_pos + 12'd4;
    rsetup(1'b0, 5'd0, t, 1'b0);
    start(16'h3FFE);
    wait_idle("R9 full done");
    check(n_dw - b_dw == 4096, "R8 zero count", n_dw - b_dw, 4096);
    for (int i = 0; i < 4096; i++) begin
      logic [16:0] da = {5'd4, t + 12'(i)};
      logic [15:0] ea = {4'h3, 12'hFFE + 12'(i)};
      if (dget(int'(da)) != mfun(ea)) bad++;
    end
    check(bad == 0, "R7 address wrap", bad, 0);
  endtask

  task automatic t_equal_pos();
    int b_dw = n_dw;
    logic [11:0] p;
    longint c0;
    wsetup(1'b1, 5'd5, 12'd1);
    p = rot_pos;
    while (rot_pos == p) @(negedge clk);
    rsetup(1'b0, 5'd0, rot_pos, 1'b0);
    c0 = cyc;
    start(16'h0010);
    wait_idle("R4 rev done");
    check((cyc - c0) >= 4095 * CPW && (cyc - c0) <= 4097 * CPW, "R4 full revolution", cyc - c0, 4096 * CPW);
    check(n_dw - b_dw == 1, "R4 one word", n_dw - b_dw, 1);
  endtask

  task automatic t_break();
    int b_dw = n_dw, b_mw = n_mw, b_irq = n_irq;
    logic [11:0] t;
    t = rot_pos + 12'd4;
    rsetup(1'b1, 5'd3, t, 1'b1);
    repeat (8 * CPW) @(negedge clk);
    check(n_irq - b_irq == 1, "R10 one irq", n_irq - b_irq, 1);
    check(irq_pos == t, "R10 irq position", irq_pos, t);
    check(n_dw == b_dw && n_mw == b_mw, "R10 no data", (n_dw - b_dw) + (n_mw - b_mw), 0);
  endtask

  task automatic t_missing_store();
    int b_dw = n_dw, b_mw = n_mw;
    logic [11:0] t;
    logic [17:0] d;
    store_ready = 1'b0;
    wsetup(1'b1, 5'd8, 12'd2);
    t = rot_pos + 12'd4;
    rsetup(1'b1, 5'd8, t, 1'b0);
    start(16'h0900);
    wait_idle("R11 busy cleared");
    readback(d);
    check(d[17] == 1'b1, "R11 err flag", d[17], 1);
    check(n_dw == b_dw && n_mw == b_mw, "R11 no transfer", (n_dw - b_dw) + (n_mw - b_mw), 0);
    store_ready = 1'b1;
    rsetup(1'b0, 5'd0, 12'd0, 1'b0);
    readback(d);
    check(d[17] == 1'b0, "R2 err cleared", d[17], 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_position();
    t_write_only();
    t_read_only();
    t_same_field();
    t_swap_fields();
    t_cancel();
    t_break();
    t_missing_store();
    t_full_track();
    t_equal_pos();
    check(n_irq == 1, "R9 no transfer irq", n_irq, 1);
    check(addr_bad == 0, "R4 slot position", addr_bad, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 190000, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule